// File: doc/BRIEF.md
# Printer-Port Register Block

This block gives a host a byte-wide register window onto a legacy printer-style parallel port. A 3-bit offset selects one of five registers. There is a data latch that drives the data pins, a status view of the peripheral's status pins, and a control register that drives the control pins. Two plain holding registers, an address byte and a data byte, are provided for enhanced-port software. Offsets 5 to 7 are empty.

The host side is a synchronous strobe bus. A write takes effect at the clock edge that samples it. A read returns its byte on `bus_rdata` one cycle later, and the byte holds there until the next read. Control bit 5 turns the data lines around. While it is set, the block stops driving the data pins, and a data read captures the external bus. Control bit 4 enables an interrupt. The interrupt is raised when the peripheral acknowledge line, status pin 6, falls. A status read clears it.

Top module: `pport_regs`

## Requirements
- R1: Offset 0 is data, 1 is status, 2 is control, 3 is the enhanced-port address byte and 4 is the enhanced-port data byte. A write to offset 0 appears on `pin_data_out` after the write edge, and a write to offset 3 or 4 reads back unchanged.
- R2: A control write stores the written byte with bits 7 and 6 forced to 1. The stored value drives `pin_ctrl` and is returned by a control read.
- R3: While control bit 5 is 0, a data read returns the last byte written to offset 0 and `pin_data_oe` is 1. While bit 5 is 1, `pin_data_oe` is 0.
- R4: While control bit 5 is 1, a data read samples `pin_data_in`, returns it and stores it in the data latch. After bit 5 is cleared, that stored byte is read back and driven out.
- R5: A status read returns `pin_status` as sampled at the read edge and clears `irq`.
- R6: When control bit 4 is 1, a falling edge on `pin_status[6]` sets `irq` at the third clock edge after the fall, through a two-flop synchroniser. When bit 4 is 0, such an edge leaves `irq` at 0.
- R7: Writes to offset 1 and to offsets 5 to 7 change no register. Reads of offsets 5 to 7 return 0xFF.
- R8: After reset the data latch is 0x00, the control register is 0xC0, `pin_data_oe` is 1, `irq` is 0 and `bus_rdata` is 0x00.
- R9: `bus_rdata` changes only at the edge that samples a read strobe. It is valid from the following cycle and holds through idle cycles and writes.
- R10: When an acknowledge event and a status read meet at the same edge, the event wins and `irq` ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_ofs | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pin_data_in | input | 8 | External data bus as seen at the pins |
| pin_data_out | output | 8 | Data latch driven toward the pins |
| pin_data_oe | output | 1 | Data driver enable, 1 = drive |
| pin_status | input | 8 | Peripheral status pins; bit 6 is acknowledge |
| pin_ctrl | output | 8 | Control register driven onto the pins |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the host never raises `bus_rd` and `bus_wr` in the same cycle. One of them checks that assumption. They also assume that `pin_status[6]` is idle high through reset, so the synchroniser, which resets to 1, sees no false fall. The bench uses tasks that issue one strobe per access, drives the pins only at falling clock edges, and keeps the acknowledge pin high whenever control bit 4 is set, except during the deliberate interrupt tests.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int OFS_W = 3;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;
  localparam logic [OFS_W-1:0] OFS_XADR = 3'd3;
  localparam logic [OFS_W-1:0] OFS_XDAT = 3'd4;

  localparam int CTL_TURN  = 5;  // data-line turnaround
  localparam int CTL_IRQEN = 4;  // acknowledge interrupt enable
  localparam int STS_ACK   = 6;  // acknowledge pin in the status byte
endpackage

// File: rtl/pport_ack_sync.sv
module pport_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst)        irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  // R5: a status read with no competing event leaves the request low
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !irq_o);

  // R10: an event always leaves the request high, even beside a read
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> irq_o);
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int DW         = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [OFS_W-1:0] bus_ofs,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [DW-1:0]    pin_data_in,
  output logic [DW-1:0]    pin_data_out,
  output logic             pin_data_oe,
  input  logic [DW-1:0]    pin_status,
  output logic [DW-1:0]    pin_ctrl,
  output logic             irq
);
  localparam logic [DW-1:0] FORCE_HI  = {2'b11, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] EMPTY_VAL = '1;

  logic [DW-1:0] data_q, ctrl_q, xadr_q, xdat_q, rdata_q;
  logic          oe_q;
  logic          ack_fall, stat_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ctrl_q  <= FORCE_HI;
      xadr_q  <= '0;
      xdat_q  <= '0;
      rdata_q <= '0;
      oe_q    <= 1'b1;
    end else begin
      if (bus_wr) begin
        case (bus_ofs)
          OFS_DATA: data_q <= bus_wdata;
          OFS_CTRL: begin
            ctrl_q <= bus_wdata | FORCE_HI;
            oe_q   <= ~bus_wdata[CTL_TURN];
          end
          OFS_XADR: xadr_q <= bus_wdata;
          OFS_XDAT: xdat_q <= bus_wdata;
          default: ;
        endcase
      end
      if (bus_rd) begin
        case (bus_ofs)
          OFS_DATA: begin
            if (ctrl_q[CTL_TURN]) begin
              data_q  <= pin_data_in;
              rdata_q <= pin_data_in;
            end else begin
              rdata_q <= data_q;
            end
          end
          OFS_STAT: rdata_q <= pin_status;
          OFS_CTRL: rdata_q <= ctrl_q;
          OFS_XADR: rdata_q <= xadr_q;
          OFS_XDAT: rdata_q <= xdat_q;
          default:  rdata_q <= EMPTY_VAL;
        endcase
      end
    end
  end

  assign stat_rd = bus_rd && (bus_ofs == OFS_STAT);

  pport_ack_sync #(.STAGES(SYNC_DEPTH)) ack_sync_i (
    .clk   (clk),
    .rst   (rst),
    .pin_i (pin_status[STS_ACK]),
    .fall_o(ack_fall)
  );

  pport_irq irq_i (
    .clk  (clk),
    .rst  (rst),
    .set_i(ack_fall && ctrl_q[CTL_IRQEN]),
    .clr_i(stat_rd),
    .irq_o(irq)
  );

  assign bus_rdata    = rdata_q;
  assign pin_data_out = data_q;
  assign pin_ctrl     = ctrl_q;
  assign pin_data_oe  = oe_q;

  // R9: the host never strobes read and write together (input assumption)
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R2: the reserved control bits stay high at all times
  a_r2_ctrl_top_high: assert property (@(posedge clk) disable iff (rst)
    pin_ctrl[DW-1:DW-2] == 2'b11);

  // R3: the driver enable is the inverse of the turnaround bit
  a_r3_oe_follows_turn: assert property (@(posedge clk) disable iff (rst)
    pin_data_oe != pin_ctrl[CTL_TURN]);

  // R4: a data read in turnaround mode captures the external bus
  a_r4_turn_capture: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_ofs == OFS_DATA && pin_ctrl[CTL_TURN])
      |=> (pin_data_out == $past(pin_data_in)));

  // R6: with the enable clear no request can appear
  a_r6_gated_off: assert property (@(posedge clk) disable iff (rst)
    (!irq && !pin_ctrl[CTL_IRQEN]) |=> !irq);

  // R7: empty offsets read as all ones
  a_r7_empty_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_ofs > OFS_XDAT) |=> (bus_rdata == EMPTY_VAL));

  // R9: read data only moves on a read strobe
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/pport_regs_tb.sv
`timescale 1ns/1ps
module pport_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_ofs = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pin_data_in = '0, pin_data_out, pin_status = 8'h40, pin_ctrl;
  logic       pin_data_oe, irq;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pport_regs dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ofs(bus_ofs),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_data_in(pin_data_in),
    .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe),
    .pin_status(pin_status), .pin_ctrl(pin_ctrl), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] o, input logic [7:0] d);
    bus_wr = 1'b1; bus_ofs = o; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] o, output logic [7:0] d);
    bus_rd = 1'b1; bus_ofs = o;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, keep;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R8 reset state
    chk("R8 data", pin_data_out, 8'h00);
    chk("R8 ctrl", pin_ctrl, 8'hC0);
    chk("R8 oe", {7'd0, pin_data_oe}, 8'h01);
    chk("R8 irq", {7'd0, irq}, 8'h00);
    chk("R8 rdata", bus_rdata, 8'h00);

    // R2 / R3 control sweep with bits 4 and 5 masked (no irq, no turnaround)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] w;
      w = 8'(v) & 8'hCF;
      wr(3'd2, w);
      chk("R2 pins", pin_ctrl, w | 8'hC0);
      chk("R3 oe", {7'd0, pin_data_oe}, 8'h01);
      rd(3'd2, r);
      chk("R2 read", r, w | 8'hC0);
    end
    wr(3'd2, 8'h00);

    // R1 / R3 data sweep
    for (int v = 0; v < 256; v++) begin
      pin_data_in = ~8'(v);
      wr(3'd0, 8'(v));
      chk("R1 data pins", pin_data_out, 8'(v));
      rd(3'd0, r);
      chk("R3 latch read", r, 8'(v));
    end

    // R1 enhanced-port holding bytes
    for (int v = 0; v < 256; v += 7) begin
      wr(3'd3, 8'(v));
      wr(3'd4, 8'(v ^ 8'h5A));
      rd(3'd3, r); chk("R1 xadr", r, 8'(v));
      rd(3'd4, r); chk("R1 xdat", r, 8'(v ^ 8'h5A));
    end

    // R7 ignored writes and empty reads
    wr(3'd0, 8'h3C); wr(3'd3, 8'h11); wr(3'd4, 8'h22);
    for (int o = 5; o < 8; o++) begin
      wr(3'(o), 8'h99);
      rd(3'(o), r);
      chk("R7 empty read", r, 8'hFF);
    end
    wr(3'd1, 8'h77);
    chk("R7 data kept", pin_data_out, 8'h3C);
    chk("R7 ctrl kept", pin_ctrl, 8'hC0);
    rd(3'd3, r); chk("R7 xadr kept", r, 8'h11);
    rd(3'd4, r); chk("R7 xdat kept", r, 8'h22);

    // R9 hold through idle and writes
    keep = r;
    idle(3);
    wr(3'd0, 8'hE1);
    chk("R9 hold", bus_rdata, keep);

    // R5 status sweep, irq disabled
    for (int v = 0; v < 256; v++) begin
      pin_status = 8'(v);
      rd(3'd1, r);
      chk("R5 status", r, 8'(v));
    end
    pin_status = 8'h40;
    idle(4);

    // R4 turnaround mode
    wr(3'd0, 8'h0F);
    wr(3'd2, 8'h20);
    chk("R3 oe off", {7'd0, pin_data_oe}, 8'h00);
    for (int v = 0; v < 256; v += 17) begin
      pin_data_in = 8'(v);
      rd(3'd0, r);
      chk("R4 ext read", r, 8'(v));
    end
    pin_data_in = 8'hA6;
    rd(3'd0, r);
    pin_data_in = 8'h00;
    wr(3'd2, 8'h00);
    chk("R4 stored pins", pin_data_out, 8'hA6);
    chk("R3 oe back", {7'd0, pin_data_oe}, 8'h01);
    rd(3'd0, r);
    chk("R4 stored read", r, 8'hA6);

    // R6 disabled: fall gives no irq
    pin_status = 8'h00; idle(5);
    chk("R6 gated", {7'd0, irq}, 8'h00);
    pin_status = 8'h40; idle(5);

    // R6 enabled: irq rises at third edge after the fall
    wr(3'd2, 8'h10);
    pin_status = 8'h00;
    idle(2);
    chk("R6 not yet", {7'd0, irq}, 8'h00);
    idle(1);
    chk("R6 raised", {7'd0, irq}, 8'h01);
    idle(2);
    chk("R6 level", {7'd0, irq}, 8'h01);
    rd(3'd1, r);
    chk("R5 read value", r, 8'h00);
    chk("R5 cleared", {7'd0, irq}, 8'h00);

    // R10 event and status read at the same edge
    pin_status = 8'h40; idle(5);
    pin_status = 8'h00;
    idle(2);
    rd(3'd1, r);
    chk("R10 set wins", {7'd0, irq}, 8'h01);
    rd(3'd1, r);
    chk("R10 later clear", {7'd0, irq}, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule